// File: doc/BRIEF.md
# Programmable Triple Parallel Port

This block is a host-bus parallel I/O controller with three 8-bit ports, named A, B and C. The host reaches it through a 2-bit address, an 8-bit write bus, an 8-bit read bus and single-cycle read and write enables, all synchronous to one clock. Each port drives its pins through a separate output latch and output-enable, and it receives its pins through a separate input vector. The enclosing pad ring combines these into the tri-state pins.

A control-register write does one of two things. A configuration word sets the direction of port A, port B, the lower half of port C and the upper half of port C. It also selects whether port A works in simple mode or in a strobed bidirectional mode. A single-bit command changes exactly one port C output bit and touches nothing else. In bidirectional mode, port A drives its pins only while an acknowledge pin on PC6 is low. A low strobe pin on PC4 captures the port A pins into a holding register that the host reads.

The parameter `PRESERVE_ON_CONFIG` selects what a configuration word does to the output latches. At 0 it clears all three output latches. At 1 it leaves them untouched, so the host can turn port A around without disturbing the outputs of ports B and C.

Top module: `tri_pio`

## Requirements
- R1: After reset all output-enables are 0, all output latches are 0, `rdata` is 0 and port A is in simple mode.
- R2: A write to address 00, 01 or 10 loads `wdata` into the port A, B or C output latch. The new value appears on `pa_out`, `pb_out` or `pc_out` after the next rising edge.
- R3: A control write with `wdata[7]`=1 is a configuration word. Bit 4 set makes port A an input, bit 1 set makes port B an input, bit 0 set makes PC0–PC3 inputs, and bit 3 set makes PC4–PC7 inputs. Each output-enable is the inverse of its bit.
- R4: With `PRESERVE_ON_CONFIG`=0, a configuration word clears all three output latches to 0x00.
- R5: With `PRESERVE_ON_CONFIG`=1, a configuration word leaves all three output latches unchanged.
- R6: A control write with `wdata[7]`=0 sets PC bit `wdata[3:1]` to `wdata[0]`. All other port C bits, the port A and B latches and every output-enable stay the same.
- R7: A read of address 00, 01 or 10 in simple mode returns the pin inputs of that port, whatever its direction. The pins are sampled at each rising edge. `rdata` updates at the edge where `rd_en` is high, from the sample taken one edge earlier.
- R8: A read of address 11 returns 0x00.
- R9: A configuration word with bit 6 set selects bidirectional mode, and bit 5 is ignored. In this mode `pa_oe` equals the inverse of `pc_in[6]`, and `pc_oe[4]` and `pc_oe[6]` are 0.
- R10: In bidirectional mode, each rising edge with `pc_in[4]` low captures `pa_in`, and edges with `pc_in[4]` high hold the captured value. A read of address 00 returns the captured value.
- R11: In bidirectional mode, PC0–PC3 keep their direction from bit 0 and PC5 and PC7 keep theirs from bit 3. Single-bit commands still drive these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 00 A, 01 B, 10 C, 11 control |
| wr_en | input | 1 | Write enable for one cycle |
| rd_en | input | 1 | Read enable for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output-enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output-enable |
| pc_in | input | 8 | Port C pin inputs (PC4 strobe, PC6 acknowledge in bidirectional mode) |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output-enable |

## Verification
A corrupted configuration register shows on the output-enables as soon as the write edge has passed, because they decode the register directly. The direction sweep covers every direction combination. A wrong clear or keep policy, or a single-bit command aimed at the wrong bit, shows on the latch outputs one edge after the write. Comparing two instances, one per policy, separates the two behaviours. A fault in the capture register or the read path shows only on the next read, two edges after the pins change, so the strobe test reads back after changing the pins on purpose.

// File: rtl/pio_pkg.sv
// Package: shared widths, select codes, configuration record and its decoder.
// Assumes an 8-bit port width; the control-word bit positions depend on it.
package pio_pkg;

    localparam int PORT_W  = 8;
    localparam int BSEL_W  = $clog2(PORT_W);
    localparam int STB_BIT = 4;   // port C pin used as strobe in bidirectional mode
    localparam int ACK_BIT = 6;   // port C pin used as acknowledge in bidirectional mode

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } pio_sel_e;

    typedef struct packed {
        logic bidir;   // port A strobed bidirectional mode
        logic a_in;    // port A is input
        logic cu_in;   // PC7..PC4 are inputs
        logic b_in;    // port B is input
        logic cl_in;   // PC3..PC0 are inputs
    } pio_cfg_t;

    localparam pio_cfg_t CFG_RESET = '{bidir: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                       b_in: 1'b1, cl_in: 1'b1};

    // Turn a configuration word into the stored record.
    function automatic pio_cfg_t decode_cfg(input logic [PORT_W-1:0] w);
        pio_cfg_t c;
        c.bidir = w[6];
        c.a_in  = w[4];
        c.cu_in = w[3];
        c.b_in  = w[1];
        c.cl_in = w[0];
        return c;
    endfunction

endpackage

// File: rtl/pio_regs.sv
// Control register and the three output latches.
// Handles data writes, configuration words (clear or keep the latches, chosen by
// PRESERVE) and single-bit port C commands. Assumes wr_en lasts one cycle per access.
module pio_regs
    import pio_pkg::*;
#(
    parameter int W        = PORT_W,
    parameter bit PRESERVE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output pio_cfg_t     cfg,
    output logic [W-1:0] a_lat,
    output logic [W-1:0] b_lat,
    output logic [W-1:0] c_lat
);
    localparam int SW = $clog2(W);

    logic ctrl_wr;
    logic cfg_wr;
    logic bsr_wr;
    logic [SW-1:0] bsr_idx;

    assign ctrl_wr = wr_en && (addr == SEL_CTRL);
    assign cfg_wr  = ctrl_wr && wdata[W-1];
    assign bsr_wr  = ctrl_wr && !wdata[W-1];
    assign bsr_idx = wdata[SW:1];

    // Configuration register: loads only on configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= CFG_RESET;
        else if (cfg_wr)
            cfg <= decode_cfg(wdata);
    end

    // Port A and B latches: data writes, plus the optional clear on configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lat <= '0;
            b_lat <= '0;
        end else if (cfg_wr && !PRESERVE) begin
            a_lat <= '0;
            b_lat <= '0;
        end else if (wr_en && addr == SEL_A) begin
            a_lat <= wdata;
        end else if (wr_en && addr == SEL_B) begin
            b_lat <= wdata;
        end
    end

    // Port C latch: data writes, single-bit commands and the optional clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_lat <= '0;
        else if (cfg_wr && !PRESERVE)
            c_lat <= '0;
        else if (bsr_wr)
            c_lat[bsr_idx] <= wdata[0];
        else if (wr_en && addr == SEL_C)
            c_lat <= wdata;
    end

endmodule

// File: rtl/pio_pins.sv
// Pin direction control and the port A strobe capture register.
// Assumes the strobe and acknowledge pins are already synchronous to clk.
module pio_pins
    import pio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pio_cfg_t     cfg,
    input  logic [W-1:0] pa_in,
    input  logic         stb_n,
    input  logic         ack_n,
    output logic         pa_oe,
    output logic         pb_oe,
    output logic [W-1:0] pc_oe,
    output logic [W-1:0] pa_cap
);
    localparam int HALF = W / 2;

    // Port A: the acknowledge pin sets the direction in bidirectional mode, the config bit otherwise.
    always_comb begin
        if (cfg.bidir)
            pa_oe = !ack_n;
        else
            pa_oe = !cfg.a_in;
    end

    assign pb_oe = !cfg.b_in;

    // Port C per-bit enables; the handshake pins become inputs in bidirectional mode.
    for (genvar i = 0; i < W; i++) begin : g_pc_dir
        if (i == STB_BIT || i == ACK_BIT) begin : g_hs
            assign pc_oe[i] = !cfg.bidir && !cfg.cu_in;
        end else if (i < HALF) begin : g_lo
            assign pc_oe[i] = !cfg.cl_in;
        end else begin : g_hi
            assign pc_oe[i] = !cfg.cu_in;
        end
    end

    // Capture register: follows the port A pins while the strobe is low in bidirectional mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pa_cap <= '0;
        else if (cfg.bidir && !stb_n)
            pa_cap <= pa_in;
    end

endmodule

// File: rtl/pio_rdpath.sv
// Read path: samples the pins every cycle and registers the addressed value on rd_en.
// Assumes the pin inputs may change at any time; one sample stage sits before rdata.
module pio_rdpath
    import pio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [1:0]   addr,
    input  logic         bidir,
    input  logic [W-1:0] pa_in,
    input  logic [W-1:0] pb_in,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] pa_cap,
    output logic [W-1:0] rdata
);
    logic [W-1:0] pa_s;
    logic [W-1:0] pb_s;
    logic [W-1:0] pc_s;
    logic [W-1:0] rd_mux;

    // Pin sample stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_s <= '0;
            pb_s <= '0;
            pc_s <= '0;
        end else begin
            pa_s <= pa_in;
            pb_s <= pb_in;
            pc_s <= pc_in;
        end
    end

    // Address select; port A returns the capture register in bidirectional mode.
    always_comb begin
        unique case (pio_sel_e'(addr))
            SEL_A:    rd_mux = bidir ? pa_cap : pa_s;
            SEL_B:    rd_mux = pb_s;
            SEL_C:    rd_mux = pc_s;
            default:  rd_mux = '0;
        endcase
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/tri_pio.sv
// Top: three-port parallel I/O controller with split pin in/out/enable vectors.
// PRESERVE_ON_CONFIG = 1 keeps the output latches across configuration words.
module tri_pio
    import pio_pkg::*;
#(
    parameter bit PRESERVE_ON_CONFIG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    pio_cfg_t          cfg;
    logic              cfg_bidir;
    logic [PORT_W-1:0] pa_cap;

    assign cfg_bidir = cfg.bidir;

    pio_regs #(.W(PORT_W), .PRESERVE(PRESERVE_ON_CONFIG)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .cfg   (cfg),
        .a_lat (pa_out),
        .b_lat (pb_out),
        .c_lat (pc_out)
    );

    pio_pins #(.W(PORT_W)) pins_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .pa_in  (pa_in),
        .stb_n  (pc_in[STB_BIT]),
        .ack_n  (pc_in[ACK_BIT]),
        .pa_oe  (pa_oe),
        .pb_oe  (pb_oe),
        .pc_oe  (pc_oe),
        .pa_cap (pa_cap)
    );

    pio_rdpath #(.W(PORT_W)) rd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .addr   (addr),
        .bidir  (cfg_bidir),
        .pa_in  (pa_in),
        .pb_in  (pb_in),
        .pc_in  (pc_in),
        .pa_cap (pa_cap),
        .rdata  (rdata)
    );

endmodule

// File: rtl/pio_chk.sv
// Checker for tri_pio: port-level properties on writes, reads and handshake pins.
module pio_chk #(
    parameter bit PRESERVE = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_out,
    input logic       pa_oe,
    input logic [7:0] pb_out,
    input logic       pb_oe,
    input logic [7:0] pc_in,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe,
    input logic       cfg_bidir
);
    // R2: a port A data write shows on the latch one edge later.
    p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b00) |=> pa_out == $past(wdata));

    // R3: port B direction follows bit 1 of a configuration word.
    p_dir_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b11 && wdata[7]) |=> pb_oe == !$past(wdata[1]));

    // R6: a single-bit command writes the chosen bit and keeps ports A and B.
    p_bsr_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b11 && !wdata[7]) |=> pc_out[$past(wdata[3:1])] == $past(wdata[0]));

    p_bsr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b11 && !wdata[7]) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pb_oe)));

    // R8: the control address reads as zero.
    p_ctrl_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'b11) |=> rdata == 8'h00);

    // R9: handshake pins stay inputs and PC6 gates port A in bidirectional mode.
    p_bidir_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bidir |-> (!pc_oe[4] && !pc_oe[6] && pa_oe == !pc_in[6]));

    // R4 / R5: the latch policy on configuration words.
    if (PRESERVE) begin : g_keep
        p_keep_on_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'b11 && wdata[7]) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
    end else begin : g_clear
        p_clear_on_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'b11 && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));
    end

endmodule

bind tri_pio pio_chk #(.PRESERVE(PRESERVE_ON_CONFIG)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pb_out    (pb_out),
    .pb_oe     (pb_oe),
    .pc_in     (pc_in),
    .pc_out    (pc_out),
    .pc_oe     (pc_oe),
    .cfg_bidir (cfg_bidir)
);

// File: tb/tri_pio_tb_top.sv
// Bench: two instances (clear policy and keep policy) on a shared bus and shared pins.
module tri_pio_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'b00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pc_in = 8'h50;

    logic [7:0] rd_c, pa_c, pb_c, pc_c, pco_c;
    logic       pao_c, pbo_c;
    logic [7:0] rd_k, pa_k, pb_k, pc_k, pco_k;
    logic       pao_k, pbo_k;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tri_pio #(.PRESERVE_ON_CONFIG(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rd_c),
        .pa_in(pa_in), .pa_out(pa_c), .pa_oe(pao_c),
        .pb_in(pb_in), .pb_out(pb_c), .pb_oe(pbo_c),
        .pc_in(pc_in), .pc_out(pc_c), .pc_oe(pco_c)
    );

    tri_pio #(.PRESERVE_ON_CONFIG(1'b1)) dut_keep_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rd_k),
        .pa_in(pa_in), .pa_out(pa_k), .pa_oe(pao_k),
        .pb_in(pb_in), .pb_out(pb_k), .pb_oe(pbo_k),
        .pc_in(pc_in), .pc_out(pc_k), .pc_oe(pco_k)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] exp_c;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state on both instances.
        chk({7'd0, pao_c}, 8'h00, "R1 pa_oe");
        chk({7'd0, pbo_c}, 8'h00, "R1 pb_oe");
        chk(pco_c, 8'h00, "R1 pc_oe");
        chk(pa_c | pb_c | pc_c, 8'h00, "R1 latches");
        chk(rd_c, 8'h00, "R1 rdata");
        chk(pa_k | pb_k | pc_k, 8'h00, "R1 keep latches");

        // R3: every combination of the four direction bits, simple mode.
        for (int m = 0; m < 16; m++) begin
            logic [7:0] w;
            w = {3'b100, m[3], m[2], 1'b0, m[1], m[0]};
            bus_wr(2'b11, w);
            chk({7'd0, pao_c}, {7'd0, ~m[3]}, "R3 pa_oe");
            chk({7'd0, pbo_c}, {7'd0, ~m[1]}, "R3 pb_oe");
            chk(pco_c, {{4{~m[2]}}, {4{~m[0]}}}, "R3 pc_oe");
            chk({7'd0, pao_k}, {7'd0, ~m[3]}, "R3 keep pa_oe");
        end

        // R2 / R4 / R5: data writes, then a configuration word under each policy.
        for (int x = 0; x < 256; x += 17) begin
            bus_wr(2'b11, 8'h80);
            bus_wr(2'b00, x[7:0]);
            bus_wr(2'b01, ~x[7:0]);
            bus_wr(2'b10, x[7:0] ^ 8'h5A);
            chk(pa_c, x[7:0], "R2 port A");
            chk(pb_c, ~x[7:0], "R2 port B");
            chk(pc_c, x[7:0] ^ 8'h5A, "R2 port C");
            bus_wr(2'b11, 8'h92);
            chk(pa_c | pb_c | pc_c, 8'h00, "R4 clear on config");
            chk(pa_k, x[7:0], "R5 keep A");
            chk(pb_k, ~x[7:0], "R5 keep B");
            chk(pc_k, x[7:0] ^ 8'h5A, "R5 keep C");
        end

        // R6: every bit and value of the single-bit command.
        bus_wr(2'b11, 8'h80);
        bus_wr(2'b00, 8'h3C);
        bus_wr(2'b01, 8'hC3);
        bus_wr(2'b10, 8'hA5);
        exp_c = 8'hA5;
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 2; v++) begin
                bus_wr(2'b11, {4'b0000, b[2:0], v[0]});
                exp_c[b] = v[0];
                chk(pc_c, exp_c, "R6 pc bit");
                chk(pc_k, exp_c, "R6 keep pc bit");
                chk(pa_c, 8'h3C, "R6 port A kept");
                chk(pb_c, 8'hC3, "R6 port B kept");
                chk({pao_c, pbo_c, 6'd0}, 8'hC0, "R6 directions kept");
                chk(pco_c, 8'hFF, "R6 pc_oe kept");
            end
        end

        // R7 / R8: reads return sampled pins in simple mode; address 11 reads zero.
        for (int p = 0; p < 256; p += 51) begin
            pa_in = p[7:0]; pb_in = p[7:0] ^ 8'hFF; pc_in = p[7:0] + 8'd7;
            idle(1);
            bus_rd(2'b00); chk(rd_c, p[7:0], "R7 read A");
            bus_rd(2'b01); chk(rd_c, p[7:0] ^ 8'hFF, "R7 read B");
            bus_rd(2'b10); chk(rd_c, p[7:0] + 8'd7, "R7 read C");
            bus_rd(2'b11); chk(rd_c, 8'h00, "R8 read ctrl");
        end

        // R9 / R11: bidirectional mode with bit 5 also set; port C outputs everywhere else.
        pc_in = 8'h50;
        bus_wr(2'b11, 8'hE0);
        chk(pco_c, 8'hAF, "R9 R11 pc_oe");
        chk({7'd0, pao_c}, 8'h00, "R9 ack high");
        pc_in = 8'h10;
        #1;
        chk({7'd0, pao_c}, 8'h01, "R9 ack low");
        pc_in = 8'h50;
        bus_wr(2'b11, 8'h03);
        chk(pc_c[1], 1'b1, "R11 bsr PC1");
        bus_wr(2'b11, 8'hE1);
        chk(pco_c, 8'hA0, "R11 lower input");

        // R10: the strobe captures the pins; the capture holds once the strobe is high.
        idle(1);
        pa_in = 8'h3C; pc_in = 8'h40;
        idle(1);
        pc_in = 8'h50; pa_in = 8'hFF;
        idle(2);
        bus_rd(2'b00); chk(rd_c, 8'h3C, "R10 captured");
        chk(rd_k, 8'h3C, "R10 keep captured");
        pa_in = 8'h81; pc_in = 8'h40;
        idle(1);
        pc_in = 8'h50;
        bus_rd(2'b00); chk(rd_c, 8'h81, "R10 recapture");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule